// File: doc/BRIEF.md
# Serial ADC Dual-Mode Read Controller

This block is the host side of a three-wire link to a 12-bit serial converter. It drives an active-low chip-select and a serial clock, and it receives one data line. A one-cycle start request carries a mode bit. The controller first sets the serial clock to the level that selects that mode, and then lowers chip-select. The converter latches the mode from the clock level at that falling edge.

The two modes differ in who times the conversion. In external-clock mode the controller supplies every clock pulse. The conversion runs inside the frame, timed by those pulses. In internal-clock mode the controller makes a single falling clock edge, which starts a conversion on the converter's own oscillator. It then holds the clock low until the data line goes high. That high level marks the end of conversion, and only after it does the controller clock out the frame. A frame is 16 bits. The controller captures each bit on a rising clock edge, because the converter changes its output on falling edges.

When the frame is complete, the controller raises chip-select and presents the 12-bit result and the channel bit with a one-cycle valid strobe. It also reports a frame error when the leading marker bits are wrong. An end-of-conversion wait that lasts too long is cut short by a timeout, which raises chip-select and pulses an error flag. The serial clock speed comes from a half-period divider parameter. It has to be fast enough that an external-mode frame fits inside the converter's hold-droop window of about 140 µs.

Top module: `sadc_reader`

## Requirements
- R1: After reset, cs_n_o is 1, sclk_o is 0, and valid, frame_err and timeout_err are 0.
- R2: When a start is accepted, sclk_o takes the level given by start_int (1 = internal clock, 0 = external clock). That level is held unchanged across the falling edge of cs_n_o.
- R3: In external mode, the controller makes exactly 16 rising and 16 falling sclk_o edges while cs_n_o is low.
- R4: In internal mode, the controller makes one falling sclk_o edge and then holds sclk_o low until sdi is seen high. It then makes 16 rising edges, which gives 17 falling edges in all while cs_n_o is low.
- R5: The controller samples sdi at each rising sclk_o edge. Rising edge k holds frame bit k. Bits 1 to 3 are the lead markers. Bit 4 appears on chan_id. Bits 5 to 16 appear on result, most significant bit first, so bit 5 goes to result[11].
- R6: If any of frame bits 1 to 3 is 0, frame_err is 1 in the valid cycle, and result and chan_id still carry the captured bits. Otherwise frame_err is 0.
- R7: If sdi stays low for EOC_LIMIT clock cycles after the internal-mode start edge, timeout_err pulses for one cycle, cs_n_o rises in that same cycle, and no valid is produced.
- R8: valid is a single-cycle pulse, issued in the cycle in which cs_n_o returns high after the last falling edge.
- R9: While cs_n_o is low, each sclk_o level lasts at least HALF_DIV clock cycles. During the bit-clocking phase, rising edges are exactly 2*HALF_DIV cycles apart.
- R10: A start_req that arrives while a transaction is in progress is ignored. It produces no extra chip-select cycle and no extra valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | One-cycle request to read a sample |
| start_int | input | 1 | Mode for the request: 1 internal clock, 0 external clock |
| sdi | input | 1 | Serial data from the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| cs_n_o | output | 1 | Active-low chip-select |
| result | output | DATA_W | Captured conversion value |
| chan_id | output | 1 | Captured channel bit |
| valid | output | 1 | One-cycle strobe when result is updated |
| frame_err | output | 1 | Lead-marker mismatch, qualified by valid |
| timeout_err | output | 1 | One-cycle pulse when the end-of-conversion wait expires |

## Verification
The bench builds the controller with HALF_DIV = 2 and EOC_LIMIT = 40. At those values a transaction takes under a hundred cycles, so the bench can sweep hundreds of data and channel values in both modes. It can also try every lead-marker pattern the converter model is able to send. The short timeout lets the bench reach both the expiry path and the case where end of conversion arrives just before expiry, and lets it measure the exact expiry cycle. The bench also varies the end-of-conversion delay, which moves the first data clock relative to the start edge.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PARK,
    ST_SEL,
    ST_WAIT,
    ST_LOW,
    ST_HIGH,
    ST_DONE
  } sadc_state_e;

endpackage

// File: rtl/sadc_half_div.sv
// Half-period tick generator for the serial clock.
module sadc_half_div #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = !clr && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr || tick) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sadc_eoc_timer.sv
// Counts cycles spent waiting for end of conversion.
module sadc_eoc_timer #(
  parameter int EOC_LIMIT = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic expired
);
  localparam int TW = $clog2(EOC_LIMIT + 1);
  localparam logic [TW-1:0] LAST = TW'(EOC_LIMIT - 1);

  logic [TW-1:0] cnt;

  assign expired = en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en)    cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sadc_frame_cap.sv
// Shift register for one serial frame, with the fields split out.
module sadc_frame_cap #(
  parameter int DATA_W = 12,
  parameter int LEAD_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              cap,
  input  logic              bit_in,
  output logic [DATA_W-1:0] data,
  output logic              chan,
  output logic              lead_ok
);
  localparam int FRAME_W = LEAD_W + 1 + DATA_W;

  logic [FRAME_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst || clr) sr <= '0;
    else if (cap)   sr <= {sr[FRAME_W-2:0], bit_in};
  end

  assign data    = sr[DATA_W-1:0];
  assign chan    = sr[DATA_W];
  assign lead_ok = &sr[FRAME_W-1 -: LEAD_W];
endmodule

// File: rtl/sadc_reader.sv
module sadc_reader #(
  parameter int HALF_DIV  = 4,
  parameter int EOC_LIMIT = 4096,
  parameter int DATA_W    = 12,
  parameter int LEAD_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_req,
  input  logic              start_int,
  input  logic              sdi,
  output logic              sclk_o,
  output logic              cs_n_o,
  output logic [DATA_W-1:0] result,
  output logic              chan_id,
  output logic              valid,
  output logic              frame_err,
  output logic              timeout_err
);
  import sadc_pkg::*;

  localparam int FRAME_W = LEAD_W + 1 + DATA_W;
  localparam int BW      = $clog2(FRAME_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W - 1);

  sadc_state_e       st;
  logic              is_int;
  logic [BW-1:0]     bitn;
  logic              tick, div_clr;
  logic              tmo;
  logic              cap_en, cap_clr;
  logic [DATA_W-1:0] cap_data;
  logic              cap_chan, cap_lead_ok;

  assign div_clr = (st == ST_IDLE) || (st == ST_WAIT);
  assign cap_en  = (st == ST_LOW) && tick;
  assign cap_clr = (st == ST_IDLE) && start_req;

  sadc_half_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rst(rst), .clr(div_clr), .tick(tick)
  );

  sadc_eoc_timer #(.EOC_LIMIT(EOC_LIMIT)) u_tmr (
    .clk(clk), .rst(rst), .en(st == ST_WAIT), .expired(tmo)
  );

  sadc_frame_cap #(.DATA_W(DATA_W), .LEAD_W(LEAD_W)) u_cap (
    .clk(clk), .rst(rst), .clr(cap_clr), .cap(cap_en), .bit_in(sdi),
    .data(cap_data), .chan(cap_chan), .lead_ok(cap_lead_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      is_int      <= 1'b0;
      bitn        <= '0;
      sclk_o      <= 1'b0;
      cs_n_o      <= 1'b1;
      result      <= '0;
      chan_id     <= 1'b0;
      valid       <= 1'b0;
      frame_err   <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      valid       <= 1'b0;
      frame_err   <= 1'b0;
      timeout_err <= 1'b0;
      case (st)
        ST_IDLE: if (start_req) begin
          is_int <= start_int;
          sclk_o <= start_int;   // mode level set up before select
          st     <= ST_PARK;
        end
        ST_PARK: if (tick) begin
          cs_n_o <= 1'b0;
          st     <= ST_SEL;
        end
        ST_SEL: if (tick) begin
          bitn <= '0;
          if (is_int) begin
            sclk_o <= 1'b0;      // single edge that starts conversion
            st     <= ST_WAIT;
          end else begin
            st     <= ST_LOW;
          end
        end
        ST_WAIT: begin
          if (sdi) begin
            st <= ST_LOW;
          end else if (tmo) begin
            cs_n_o      <= 1'b1;
            timeout_err <= 1'b1;
            st          <= ST_IDLE;
          end
        end
        ST_LOW: if (tick) begin
          sclk_o <= 1'b1;        // data captured on this edge
          st     <= ST_HIGH;
        end
        ST_HIGH: if (tick) begin
          sclk_o <= 1'b0;
          if (bitn == LAST_BIT) begin
            st <= ST_DONE;
          end else begin
            bitn <= bitn + 1'b1;
            st   <= ST_LOW;
          end
        end
        ST_DONE: if (tick) begin
          cs_n_o    <= 1'b1;
          valid     <= 1'b1;
          result    <= cap_data;
          chan_id   <= cap_chan;
          frame_err <= !cap_lead_ok;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sadc_reader_chk.sv
module sadc_reader_chk #(
  parameter int HALF_DIV = 4
) (
  input logic clk,
  input logic rst,
  input logic sclk_o,
  input logic cs_n_o,
  input logic valid,
  input logic frame_err,
  input logic timeout_err
);
  localparam int HW = $clog2(HALF_DIV + 1) + 1;

  logic          sclk_q;
  logic [HW-1:0] hold_cnt;
  logic          sclk_chg;

  assign sclk_chg = (sclk_o != sclk_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q   <= 1'b0;
      hold_cnt <= '0;
    end else begin
      sclk_q <= sclk_o;
      if (sclk_chg)                   hold_cnt <= HW'(1);
      else if (hold_cnt < HW'(HALF_DIV)) hold_cnt <= hold_cnt + 1'b1;
    end
  end

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  p_valid_cs_r8: assert property (@(posedge clk) disable iff (rst)
    valid |-> $rose(cs_n_o));

  p_ferr_qual_r6: assert property (@(posedge clk) disable iff (rst)
    frame_err |-> valid);

  p_timeout_release_r7: assert property (@(posedge clk) disable iff (rst)
    timeout_err |-> ($rose(cs_n_o) && !valid));

  p_mode_hold_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_o) |-> $stable(sclk_o));

  p_half_period_r9: assert property (@(posedge clk) disable iff (rst)
    (!cs_n_o && sclk_chg) |-> (hold_cnt >= HW'(HALF_DIV)));
endmodule

bind sadc_reader sadc_reader_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk(clk), .rst(rst), .sclk_o(sclk_o), .cs_n_o(cs_n_o),
  .valid(valid), .frame_err(frame_err), .timeout_err(timeout_err)
);

// File: tb/sadc_reader_test.sv
`timescale 1ns/1ps
module sadc_reader_test;
  localparam int HALF  = 2;
  localparam int LIMIT = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_req = 1'b0;
  logic start_int = 1'b0;
  logic sdi = 1'b0;
  logic sclk_o, cs_n_o, chan_id, valid, frame_err, timeout_err;
  logic [11:0] result;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  sadc_reader #(.HALF_DIV(HALF), .EOC_LIMIT(LIMIT)) uut (
    .clk(clk), .rst(rst), .start_req(start_req), .start_int(start_int),
    .sdi(sdi), .sclk_o(sclk_o), .cs_n_o(cs_n_o), .result(result),
    .chan_id(chan_id), .valid(valid), .frame_err(frame_err),
    .timeout_err(timeout_err)
  );

  // ---------------- converter model ----------------
  logic [15:0] frame_q = '0;
  int  conv_dly = 0;
  bit  eoc_never = 0;
  bit  m_int = 0, first_done = 0, per_bad = 0;
  int  pos = 0, rises = 0, falls = 0, cs_falls = 0, valids = 0;
  logic lvl_cs = 1'b0;
  realtime last_rise = 0, t_fall = 0;

  always @(negedge cs_n_o) begin
    lvl_cs = sclk_o; m_int = sclk_o; first_done = 0; pos = 0;
    rises = 0; falls = 0; per_bad = 0; cs_falls++;
    sdi = m_int ? 1'b0 : frame_q[15];
  end

  always @(posedge cs_n_o) sdi = 1'b0;

  always @(posedge sclk_o) if (cs_n_o === 1'b0) begin
    if (rises > 0 && ($realtime - last_rise) != 2 * HALF * 10.0) per_bad = 1;
    last_rise = $realtime;
    rises++;
  end

  always @(negedge sclk_o) if (cs_n_o === 1'b0) begin
    falls++;
    if (m_int && !first_done) begin
      first_done = 1;
      t_fall = $realtime;
      fork
        begin
          repeat (conv_dly + 1) @(negedge clk);
          if (!cs_n_o && !eoc_never) sdi = frame_q[15];
        end
      join_none
    end else begin
      pos++;
      sdi = (pos < 16) ? frame_q[15 - pos] : 1'b0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (valid) valids++;
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_txn(input bit mode, input logic [2:0] lead, input logic ch,
                         input logic [11:0] d, input int dly, input bit never,
                         input bit poke);
    bit got_v, got_t;
    int v0, c0;
    frame_q = {lead, ch, d};
    conv_dly = dly; eoc_never = never;
    v0 = valids; c0 = cs_falls;
    @(negedge clk); start_req = 1'b1; start_int = mode;
    @(negedge clk); start_req = 1'b0;
    got_v = 0; got_t = 0;
    for (int i = 0; i < 2000; i++) begin
      if (poke && i == 10) start_req = 1'b1;
      if (poke && i == 11) start_req = 1'b0;
      if (valid) begin got_v = 1; break; end
      if (timeout_err) begin got_t = 1; break; end
      @(negedge clk);
    end
    chk(lvl_cs == mode, "R2", lvl_cs, mode);
    if (never) begin
      int dt;
      dt = int'($realtime - t_fall);
      chk(got_t && !got_v, "R7", got_t, 1);
      chk(dt == LIMIT * 10 + 5, "R7", dt, LIMIT * 10 + 5);
      chk(cs_n_o == 1'b1, "R7", cs_n_o, 1);
      chk(valids == v0, "R7", valids - v0, 0);
    end else begin
      chk(got_v, "R8", got_v, 1);
      chk(cs_n_o == 1'b1, "R8", cs_n_o, 1);
      chk(result == d, "R5", result, d);
      chk(chan_id == ch, "R5", chan_id, ch);
      chk(frame_err == (lead != 3'b111), "R6", frame_err, lead != 3'b111);
      chk(rises == 16, mode ? "R4" : "R3", rises, 16);
      chk(falls == (mode ? 17 : 16), mode ? "R4" : "R3", falls, mode ? 17 : 16);
      chk(!per_bad, "R9", per_bad, 0);
      @(negedge clk);
      chk(!valid, "R8", valid, 0);
    end
    if (poke) begin
      repeat (120) @(negedge clk);
      chk(cs_falls - c0 == 1, "R10", cs_falls - c0, 1);
      chk(valids - v0 == 1, "R10", valids - v0, 1);
      chk(cs_n_o == 1'b1, "R10", cs_n_o, 1);
    end
    repeat (3) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    wait (cyc > 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (4) @(negedge clk);
    chk(cs_n_o == 1'b1, "R1", cs_n_o, 1);
    chk(sclk_o == 1'b0, "R1", sclk_o, 0);
    chk(!valid && !frame_err && !timeout_err, "R1",
        {valid, frame_err, timeout_err}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R3 R5: external-mode sweep over data and channel
    for (int i = 0; i < 160; i++) begin
      logic [11:0] d;
      d = 12'((i * 26) ^ (i << 5)) ^ ((i % 3 == 0) ? 12'hFFF : 12'h000);
      run_txn(1'b0, 3'b111, i[0], d, 0, 0, 0);
    end
    // R4 R5: internal-mode sweep with varying conversion delay
    for (int i = 0; i < 160; i++) begin
      logic [11:0] d;
      d = 12'((i * 41) ^ (i << 4));
      run_txn(1'b1, 3'b111, i[1], d, i % 12, 0, 0);
    end
    // walking ones, both modes
    for (int b = 0; b < 12; b++) begin
      run_txn(1'b0, 3'b111, 1'b0, 12'(1 << b), 0, 0, 0);
      run_txn(1'b1, 3'b111, 1'b1, 12'(1 << b), 3, 0, 0);
    end
    // R6: every lead pattern in external mode, those with bit 1 set in internal
    for (int l = 0; l < 8; l++) begin
      run_txn(1'b0, 3'(l), 1'b1, 12'hA5C, 0, 0, 0);
      if (l >= 4) run_txn(1'b1, 3'(l), 1'b0, 12'h3C9, 2, 0, 0);
    end
    // R7: end of conversion never arrives; then just before expiry
    run_txn(1'b1, 3'b111, 1'b0, 12'h123, 0, 1, 0);
    run_txn(1'b1, 3'b111, 1'b1, 12'hFED, LIMIT - 3, 0, 0);
    run_txn(1'b1, 3'b111, 1'b0, 12'h456, 0, 1, 0);
    // R10: second request while busy, both modes
    run_txn(1'b0, 3'b111, 1'b1, 12'h777, 0, 0, 1);
    run_txn(1'b1, 3'b111, 1'b0, 12'h888, 4, 0, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule